// File: doc/BRIEF.md
# Serial Audio Link Frame Receiver

This block is the receive half of a fixed-rate, time-division-multiplexed serial audio link. A single data line arrives together with a bit clock and a frame marker. The block samples the line on every falling edge of the bit clock and aligns frames to the rising edge of the marker. Each 256-bit frame is cut into a 16-bit tag field and twelve 20-bit slot words.

The tag field says which slots carry valid data and whether the far end is ready. When a complete frame has been captured, the block updates a parallel image of all twelve slots. That image holds one valid flag per slot, the slot words (zeroed where the slot is not tagged valid) and a ready flag. It also pulses a frame-done strobe for one cycle. Downstream logic must not start capture or playback until the ready flag has been seen high.

Frames that are cut short by an early frame-marker edge are dropped without trace. A frame marker that fails to rise where a frame should begin drops alignment until the next rising edge.

Top module: `aclink_rx`

## Requirements
- R1: While `rst_n` is low and after it is released, `frame_done`, `codec_ready`, `slot_valid` and `slot_data` are all zero until the first complete frame has been received.
- R2: `sdata_in` and `sync` are sampled on falling edges of `bit_clk`. The bit sampled at the first falling edge where `sync` is seen high after being seen low is frame bit 0. Every field arrives most significant bit first.
- R3: Frame bits 0 to 15 form the tag. Tag bit 15 (frame bit 0) drives `codec_ready`. Tag bit 15-k (k = 1..12) drives `slot_valid[k-1]`.
- R4: Slot k (k = 1..12) occupies frame bits 16+20(k-1) to 35+20(k-1). When slot k is valid, its word appears on `slot_data[20(k-1)+19 : 20(k-1)]`.
- R5: The slice of `slot_data` for a slot whose tag bit is 0 reads as all zeros.
- R6: Tag bits 2 to 0 are reserved and have no effect on any output.
- R7: `frame_done` is high for exactly one bit-clock cycle, starting at the falling edge on which frame bit 255 is sampled. All other outputs change only at that edge and hold their values between frames.
- R8: If `sync` rises at any bit position other than frame bit 0, the bit count restarts at that edge and the interrupted frame produces no `frame_done` and no output change. The frame that follows the restart is received normally.
- R9: Before the first rising edge of `sync`, and whenever `sync` has not risen at the bit position where the next frame should begin, incoming bits are ignored. No output changes until `sync` rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock; data and `sync` sampled on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Frame marker; its rising edge marks frame bit 0 |
| sdata_in | input | 1 | Incoming serial data line |
| frame_done | output | 1 | One-cycle strobe after a complete frame |
| codec_ready | output | 1 | Ready flag from the last complete frame's tag |
| slot_valid | output | 12 | Per-slot valid flags; bit k-1 is slot k |
| slot_data | output | 240 | Slot words; slot k at bits 20(k-1)+19 down to 20(k-1) |

## Verification
The hardest situations to reach from the ports are the loss and recovery of frame alignment. One case is a frame-marker edge that arrives partway through a frame. The other is a frame boundary that passes with no marker edge at all. In both cases, the evidence is something that must not happen.

The stimulus builds these cases by aborting a frame after 150 bits and immediately starting a new one. It also sends a full 256-bit stretch with the marker held low. In both cases it confirms that no strobe appears and that the parallel image still holds the last complete frame. Only then does it check that the next properly marked frame is captured in full.

// File: rtl/aclink_rx.sv
module aclink_rx #(
  parameter int SLOT_W = 20,
  parameter int NSLOT  = 12,
  parameter int TAG_W  = 16
) (
  input  logic                     bit_clk,
  input  logic                     rst_n,
  input  logic                     sync,
  input  logic                     sdata_in,
  output logic                     frame_done,
  output logic                     codec_ready,
  output logic [NSLOT-1:0]         slot_valid,
  output logic [NSLOT*SLOT_W-1:0]  slot_data
);
  localparam int FRAME = TAG_W + SLOT_W * NSLOT;
  localparam int PW    = $clog2(FRAME);
  localparam int BW    = $clog2(SLOT_W);
  localparam int SW    = $clog2(NSLOT + 1);

  logic              sync_q, active;
  logic [PW-1:0]     pos;
  logic [BW-1:0]     bi;
  logic [SW-1:0]     si;
  logic [SLOT_W-2:0] sh;
  logic [TAG_W-1:0]  tag_q;
  logic [SLOT_W-1:0] wbuf [NSLOT];

  wire              rise = sync & ~sync_q;
  wire [SLOT_W-1:0] word = {sh, sdata_in};
  wire              last = (pos == PW'(FRAME - 1));

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q      <= 1'b0;
      active      <= 1'b0;
      pos         <= '0;
      bi          <= '0;
      si          <= '0;
      sh          <= '0;
      tag_q       <= '0;
      frame_done  <= 1'b0;
      codec_ready <= 1'b0;
      slot_valid  <= '0;
      slot_data   <= '0;
      for (int k = 0; k < NSLOT; k++) wbuf[k] <= '0;
    end else begin
      sync_q     <= sync;
      frame_done <= 1'b0;
      if (rise) begin
        active <= 1'b1;
        pos    <= PW'(1);
        bi     <= '0;
        si     <= '0;
        sh     <= word[SLOT_W-2:0];
      end else if (active && pos == '0) begin
        active <= 1'b0;
      end else if (active) begin
        pos <= last ? '0 : pos + 1'b1;
        sh  <= word[SLOT_W-2:0];
        if (pos == PW'(TAG_W - 1))
          tag_q <= {sh[TAG_W-2:0], sdata_in};
        if (pos >= PW'(TAG_W)) begin
          if (bi == BW'(SLOT_W - 1)) begin
            bi       <= '0;
            si       <= si + 1'b1;
            wbuf[si] <= word;
          end else begin
            bi <= bi + 1'b1;
          end
        end
        if (last) begin
          frame_done  <= 1'b1;
          codec_ready <= tag_q[TAG_W-1];
          for (int k = 0; k < NSLOT; k++) begin
            slot_valid[k] <= tag_q[TAG_W-2-k];
            if (!tag_q[TAG_W-2-k])
              slot_data[k*SLOT_W +: SLOT_W] <= '0;
            else if (k == NSLOT - 1)
              slot_data[k*SLOT_W +: SLOT_W] <= word;
            else
              slot_data[k*SLOT_W +: SLOT_W] <= wbuf[k];
          end
        end
      end
    end
  end
endmodule

// File: rtl/aclink_rx_chk.sv
module aclink_rx_chk #(
  parameter int SLOT_W = 20,
  parameter int NSLOT  = 12
) (
  input logic                    bit_clk,
  input logic                    rst_n,
  input logic                    frame_done,
  input logic                    codec_ready,
  input logic [NSLOT-1:0]        slot_valid,
  input logic [NSLOT*SLOT_W-1:0] slot_data
);
  logic [15:0] gap;
  logic        seen;

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (frame_done) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != 16'hFFFF) begin
      gap <= gap + 1'b1;
    end
  end

  AST_DONE_SINGLE: assert property (@(negedge bit_clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R7
  AST_VALID_HOLD: assert property (@(negedge bit_clk) disable iff (!rst_n)
    !frame_done |-> $stable(slot_valid)); // R7
  AST_READY_HOLD: assert property (@(negedge bit_clk) disable iff (!rst_n)
    !frame_done |-> $stable(codec_ready)); // R7
  AST_DATA_HOLD: assert property (@(negedge bit_clk) disable iff (!rst_n)
    !frame_done |-> $stable(slot_data)); // R8
  AST_FRAME_SPACING: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (frame_done && seen) |-> gap >= 16'd255); // R8

  for (genvar k = 0; k < NSLOT; k++) begin : g_zero
    AST_INVALID_ZERO: assert property (@(negedge bit_clk) disable iff (!rst_n)
      !slot_valid[k] |-> slot_data[k*SLOT_W +: SLOT_W] == '0); // R5
  end
endmodule

bind aclink_rx aclink_rx_chk #(.SLOT_W(SLOT_W), .NSLOT(NSLOT)) u_chk (
  .bit_clk(bit_clk), .rst_n(rst_n), .frame_done(frame_done),
  .codec_ready(codec_ready), .slot_valid(slot_valid), .slot_data(slot_data));

// File: tb/aclink_rx_tb.sv
`timescale 1ns/1ps
module aclink_rx_tb;
  logic clk = 1'b0, rst_n = 1'b0, sync = 1'b0, sdata_in = 1'b0;
  logic frame_done, codec_ready;
  logic [11:0]  slot_valid;
  logic [239:0] slot_data;

  int n_chk = 0, n_bad = 0;
  bit pending = 0;
  logic         cur_rdy = 0, nxt_rdy;
  logic [11:0]  cur_val = '0, nxt_val;
  logic [239:0] cur_dat = '0, nxt_dat;

  always #10 clk = ~clk;

  aclink_rx u_dut (.bit_clk(clk), .rst_n(rst_n), .sync(sync), .sdata_in(sdata_in),
    .frame_done(frame_done), .codec_ready(codec_ready),
    .slot_valid(slot_valid), .slot_data(slot_data));

  function automatic logic [19:0] wgen(int f, int k);
    return 20'((f * 40503 + k * 7919 + 370085) ^ (k << (f % 9)));
  endfunction

  function automatic logic [15:0] tgen(int f);
    logic [11:0] m;
    if (f < 12)       m = 12'(1 << (11 - f));
    else if (f == 12) m = 12'hFFF;
    else if (f == 13) m = 12'h000;
    else if (f == 14) m = 12'hAAA;
    else if (f == 15) m = 12'h555;
    else              m = 12'((f * 1103515245 + 12345) >>> 9);
    return {1'((f % 3) != 1), m, 3'(f % 8)};
  endfunction

  function automatic logic fbit(int f, int b);
    logic [15:0] t;
    logic [19:0] w;
    t = tgen(f);
    if (b < 16) return t[15 - b];
    w = wgen(f, (b - 16) / 20);
    return w[19 - ((b - 16) % 20)];
  endfunction

  task automatic chk(bit ok, string req, string what, logic [19:0] act, logic [19:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic hold_check(string req);
    chk(frame_done == 1'b0, req, "strobe between frames", 20'(frame_done), 20'h0);
    chk(codec_ready == cur_rdy, req, "ready held", 20'(codec_ready), 20'(cur_rdy));
    chk(slot_valid == cur_val, req, "valid held", 20'(slot_valid), 20'(cur_val));
    chk(slot_data == cur_dat, req, "data held", slot_data[19:0] ^ slot_data[239:220],
        cur_dat[19:0] ^ cur_dat[239:220]);
  endtask

  task automatic check_pending(string req);
    if (pending) begin
      chk(frame_done == 1'b1, "R7", "strobe after bit 255", 20'(frame_done), 20'h1);
      chk(codec_ready == nxt_rdy, "R3", "ready flag", 20'(codec_ready), 20'(nxt_rdy));
      chk(slot_valid == nxt_val, "R3 R6", "valid flags", 20'(slot_valid), 20'(nxt_val));
      for (int k = 0; k < 12; k++)
        chk(slot_data[k*20 +: 20] == nxt_dat[k*20 +: 20], nxt_val[k] ? "R4" : "R5",
            $sformatf("slot %0d word", k + 1), slot_data[k*20 +: 20], nxt_dat[k*20 +: 20]);
      cur_rdy = nxt_rdy; cur_val = nxt_val; cur_dat = nxt_dat;
      pending = 0;
    end else begin
      chk(frame_done == 1'b0, req, "no strobe without full frame", 20'(frame_done), 20'h0);
    end
  endtask

  task automatic frame(int f, int len, bit sen, string req);
    logic [15:0] t;
    for (int b = 0; b < len; b++) begin
      @(posedge clk);
      sync     = sen && (b < 16);
      sdata_in = fbit(f, b);
      if (b == 0) check_pending(req);
      if (b == 1) chk(frame_done == 1'b0, "R7", "strobe width", 20'(frame_done), 20'h0);
      if (b == 100) hold_check(req);
    end
    if (len == 256 && sen) begin
      t = tgen(f);
      nxt_rdy = t[15];
      for (int k = 0; k < 12; k++) begin
        nxt_val[k] = t[14 - k];
        nxt_dat[k*20 +: 20] = t[14 - k] ? wgen(f, k) : 20'h0;
      end
      pending = 1;
    end
  endtask

  initial begin
    fork
      begin
        repeat (4) @(posedge clk);
        chk(frame_done == 0 && codec_ready == 0, "R1", "ctrl in reset", 20'({frame_done, codec_ready}), 20'h0);
        chk(slot_valid == 0 && slot_data == 0, "R1", "image in reset", slot_data[19:0], 20'h0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        chk(slot_valid == 0 && codec_ready == 0, "R1", "after release", 20'(slot_valid), 20'h0);
        frame(99, 256, 0, "R9");
        for (int f = 0; f < 30; f++) frame(f, 256, 1, "R2");
        frame(30, 150, 1, "R8");
        frame(31, 256, 1, "R8");
        frame(32, 256, 1, "R8");
        frame(33, 256, 0, "R9");
        frame(34, 256, 1, "R9");
        for (int f = 35; f < 40; f++) frame(f, 256, 1, "R2");
        frame(40, 2, 1, "R7");
      end
      begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 20'h0, 20'h1);
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule